// File: doc/BRIEF.md
# Maskable Interrupt Line Collector

The block gathers up to thirty external interrupt lines and folds them into one interrupt request for a processor's interrupt controller. Every line first goes through a two-stage synchroniser and, if software asks for it, a debounce filter that only accepts a new level once it has held for a programmable number of cycles. Each line can be enabled or disabled, masked, set to follow a level or to catch an edge, and set to active-high (rising edge) or active-low (falling edge).

In edge mode a detected edge leaves a sticky pending bit. Software clears it by writing 1 to that bit of the acknowledge register. Two status views are readable: pending bits before masking and pending bits after masking. The uplink request is the OR of the masked view. With only one line enabled and unmasked in level mode, the request follows that input like a wire, two cycles behind it.

Software reaches the block through a 32-bit single-cycle write port and a combinational read port.

Top module: `irq_collector`

## Requirements
- R1: After a synchronous active-low reset, enable, mask, type, polarity, debounce-select and debounce-length all read 0, both status views read 0 and `irq_out` is 0.
- R2: Enable (0x30), mask (0x34), type (0x38), polarity (0x3C), debounce-select (0x48) and debounce-length (0x50, low 8 bits) read back what was written. Bits 31:30 always read 0, and any unmapped offset reads 0.
- R3: In level mode (type bit 0) a line's raw pending bit (raw status at 0x44) equals enable AND the line's active level, two clock edges after the input changes.
- R4: Polarity bit 1 makes a line active-high, or rising-edge in edge mode. Polarity bit 0 makes it active-low, or falling-edge in edge mode.
- R5: In edge mode (type bit 1) an active edge sets a pending bit three edges after the input change. The bit stays set after the input returns.
- R6: Writing the acknowledge register (0x4C) clears the edge pending bits whose data bits are 1 and leaves the other bits unchanged. If an edge arrives in the same cycle, the set wins.
- R7: A mask bit of 1 removes that line from the masked status (0x40) and from `irq_out`, while the raw status still shows it.
- R8: A line whose enable bit is 0 shows no pending bit. Clearing the enable bit also discards a sticky edge pending bit.
- R9: `irq_out` is 1 exactly when the masked status is non-zero.
- R10: For a line with its debounce-select bit set and debounce length L, an input pulse of L cycles or fewer is rejected and a level held for L+1 cycles or more is accepted. Lines without debounce-select are not filtered.
- R11: With a single line enabled, unmasked, level mode and active-high, `irq_out` follows that input after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 30 | Asynchronous interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions check several properties on every cycle. The request must match the OR of the unmasked raw pending bits. A disabled line must never show pending. Masked bits must never appear in the masked status read. An edge pending bit must not drop unless it was acknowledged or disabled. The bits above the line count must always read 0. The bench scenarios cover the rest: the exact latency through the synchroniser, falling-edge capture under low polarity, debounce rejection of short pulses against acceptance of long ones, and the register read-back values.

// File: rtl/irq_collector_pkg.sv
// Package: shared constants for the interrupt collector.
// Assumes byte offsets on an 8-bit address; the offsets are fixed by software.
package irq_collector_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_TYPE   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_POL    = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_DEBSEL = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_DEBLEN = 8'h50;
endpackage

// File: rtl/irq_line_filter.sv
// Module: irq_line_filter
// Two-flop synchroniser followed by an optional debounce stage for one line.
// Assumes deb_len is quasi-static. With deb_sel low the synchronised value
// passes straight through; with it high a change is accepted only after it
// has been held while the counter climbs to deb_len.
module irq_line_filter #(
    parameter int DEB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             deb_sel,
    input  logic [DEB_W-1:0] deb_len,
    output logic             level
);
    logic             meta_q;
    logic             sync_q;
    logic             held_q;
    logic [DEB_W-1:0] run_q;

    // Purpose: bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
        end
    end

    // Purpose: count how long the synchronised value has differed from the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            run_q  <= '0;
        end else if (sync_q == held_q) begin
            run_q  <= '0;
        end else if (run_q == deb_len) begin
            held_q <= sync_q;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    // Purpose: pick the filtered or the plain synchronised value.
    always_comb begin
        level = deb_sel ? held_q : sync_q;
    end
endmodule

// File: rtl/irq_line_detect.sv
// Module: irq_line_detect
// Turns one filtered line into a pending bit, by level or by sticky edge.
// Assumes the polarity bit sets the active sense. The previous active value
// is tracked at all times, so enabling a line does not create a false edge.
module irq_line_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic enable,
    input  logic edge_mode,
    input  logic active_high,
    input  logic ack,
    output logic pending
);
    logic active;
    logic prev_q;
    logic sticky_q;
    logic hit;

    // Purpose: normalise the line to an active-high sense.
    always_comb begin
        active = active_high ? level : ~level;
        hit    = active & ~prev_q;
    end

    // Purpose: remember the active value of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= active;
    end

    // Purpose: hold an edge until it is acknowledged or the line is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       sticky_q <= 1'b0;
        else if (!enable) sticky_q <= 1'b0;
        else if (hit)     sticky_q <= 1'b1;
        else if (ack)     sticky_q <= 1'b0;
    end

    // Purpose: present the pending bit for the selected mode.
    always_comb begin
        pending = enable & (edge_mode ? sticky_q : active);
    end
endmodule

// File: rtl/irq_reg_file.sv
// Module: irq_reg_file
// Holds the configuration registers, decodes the acknowledge strobe and
// drives the combinational read data. Assumes a single-cycle write strobe.
module irq_reg_file
    import irq_collector_pkg::*;
#(
    parameter int NLINES = 30,
    parameter int DEB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NLINES-1:0] raw,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NLINES-1:0] en_q,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] type_q,
    output logic [NLINES-1:0] pol_q,
    output logic [NLINES-1:0] debsel_q,
    output logic [DEB_W-1:0]  deblen_q,
    output logic [NLINES-1:0] ack
);
    logic [NLINES-1:0] wbits;
    logic [NLINES-1:0] masked;
    logic              unused_wdata_hi;

    // Purpose: split the write data into line bits.
    always_comb begin
        wbits           = reg_wdata[NLINES-1:0];
        unused_wdata_hi = ^reg_wdata;
        masked          = raw & ~mask_q;
    end

    // Purpose: store configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            mask_q   <= '0;
            type_q   <= '0;
            pol_q    <= '0;
            debsel_q <= '0;
            deblen_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_ENABLE: en_q     <= wbits;
                OFS_MASK:   mask_q   <= wbits;
                OFS_TYPE:   type_q   <= wbits;
                OFS_POL:    pol_q    <= wbits;
                OFS_DEBSEL: debsel_q <= wbits;
                OFS_DEBLEN: deblen_q <= reg_wdata[DEB_W-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: decode write-one-to-clear acknowledge bits.
    always_comb begin
        ack = (reg_we && reg_addr == OFS_ACK) ? wbits : '0;
    end

    // Purpose: return the register addressed by reg_addr.
    always_comb begin
        case (reg_addr)
            OFS_ENABLE: reg_rdata = DATA_W'(en_q);
            OFS_MASK:   reg_rdata = DATA_W'(mask_q);
            OFS_TYPE:   reg_rdata = DATA_W'(type_q);
            OFS_POL:    reg_rdata = DATA_W'(pol_q);
            OFS_STAT:   reg_rdata = DATA_W'(masked);
            OFS_RAW:    reg_rdata = DATA_W'(raw);
            OFS_DEBSEL: reg_rdata = DATA_W'(debsel_q);
            OFS_DEBLEN: reg_rdata = DATA_W'(deblen_q);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_collector.sv
// Module: irq_collector
// Top level: per-line filter and detector, register file, OR reduction to a
// single request. Assumes NLINES <= 32 and asynchronous line inputs.
module irq_collector
    import irq_collector_pkg::*;
#(
    parameter int NLINES = 30,
    parameter int DEB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    logic [NLINES-1:0] en_q;
    logic [NLINES-1:0] mask_q;
    logic [NLINES-1:0] type_q;
    logic [NLINES-1:0] pol_q;
    logic [NLINES-1:0] debsel_q;
    logic [DEB_W-1:0]  deblen_q;
    logic [NLINES-1:0] ack;
    logic [NLINES-1:0] level;
    logic [NLINES-1:0] raw;

    irq_reg_file #(.NLINES(NLINES), .DEB_W(DEB_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw       (raw),
        .reg_rdata (reg_rdata),
        .en_q      (en_q),
        .mask_q    (mask_q),
        .type_q    (type_q),
        .pol_q     (pol_q),
        .debsel_q  (debsel_q),
        .deblen_q  (deblen_q),
        .ack       (ack)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        irq_line_filter #(.DEB_W(DEB_W)) filt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (line_in[i]),
            .deb_sel (debsel_q[i]),
            .deb_len (deblen_q),
            .level   (level[i])
        );
        irq_line_detect det_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .level       (level[i]),
            .enable      (en_q[i]),
            .edge_mode   (type_q[i]),
            .active_high (pol_q[i]),
            .ack         (ack[i]),
            .pending     (raw[i])
        );
    end

    // Purpose: collapse every unmasked pending line into the uplink request.
    always_comb begin
        irq_out = |(raw & ~mask_q);
    end
endmodule

// File: rtl/irq_collector_chk.sv
// Module: irq_collector_chk
// Cycle-by-cycle properties of the collector, bound into the top module.
// Assumes the register offsets of the package.
module irq_collector_chk
    import irq_collector_pkg::*;
#(
    parameter int NLINES = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out,
    input logic [NLINES-1:0] raw,
    input logic [NLINES-1:0] en_q,
    input logic [NLINES-1:0] mask_q,
    input logic [NLINES-1:0] type_q
);
    logic [NLINES-1:0] ack_vec;
    logic [NLINES-1:0] hold_vec;

    // Purpose: rebuild the acknowledge bits from the port view.
    always_comb begin
        ack_vec = (reg_we && reg_addr == OFS_ACK) ? reg_wdata[NLINES-1:0] : '0;
    end

    // Purpose: register the edge bits that must survive into this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_vec <= '0;
        else        hold_vec <= raw & type_q & en_q & ~ack_vec;
    end

    assert_or_of_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |(raw & ~mask_q));

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~en_q) == '0);

    assert_mask_hides_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT) |-> ((reg_rdata[NLINES-1:0] & mask_q) == '0));

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold_vec & type_q & en_q & ~raw) == '0));

    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NLINES] == '0);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == 1'b0));
endmodule

bind irq_collector irq_collector_chk #(.NLINES(NLINES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .raw       (raw),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .type_q    (type_q)
);

// File: tb/irq_collector_tb_top.sv
// Bench for irq_collector: a table of level-mode vectors, then directed tests.
module irq_collector_tb_top;
    import irq_collector_pkg::*;

    localparam int NL = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL-1:0]     line_in = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_collector #(.NLINES(NL), .DEB_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // Vector fields: {enable[3:0], mask[3:0], pol[3:0], in[3:0], raw[3:0], irq}, level mode.
    localparam logic [20:0] VEC [8] = '{
        21'b0001_0000_1111_0001_0001_1,
        21'b0001_0000_1111_0000_0000_0,
        21'b0011_0000_0000_0001_0010_1,
        21'b0011_0010_0000_0001_0010_0,
        21'b1111_0101_1010_1010_1111_1,
        21'b1111_1111_1010_1010_1111_0,
        21'b0000_0000_1111_1111_0000_0,
        21'b1100_0100_1111_0100_0100_0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; line_in = '0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1: reset state of every register and the request
        foreach (VEC[k]) begin end
        rd(OFS_ENABLE, v); check("R1 enable", v, 0);
        rd(OFS_MASK, v);   check("R1 mask", v, 0);
        rd(OFS_TYPE, v);   check("R1 type", v, 0);
        rd(OFS_POL, v);    check("R1 pol", v, 0);
        rd(OFS_DEBSEL, v); check("R1 debsel", v, 0);
        rd(OFS_DEBLEN, v); check("R1 deblen", v, 0);
        rd(OFS_RAW, v);    check("R1 raw", v, 0);
        rd(OFS_STAT, v);   check("R1 stat", v, 0);
        check("R1 irq", {31'b0, irq_out}, 0);

        // R3 R4 R7 R8 R9 R11: vector table, level mode
        for (int k = 0; k < 8; k++) begin
            wr(OFS_ENABLE, {28'b0, VEC[k][20:17]});
            wr(OFS_MASK,   {28'b0, VEC[k][16:13]});
            wr(OFS_POL,    {28'b0, VEC[k][12:9]});
            line_in = {26'b0, VEC[k][8:5]};
            cycles(3);
            rd(OFS_RAW, v);
            check($sformatf("R3 raw vec%0d", k), v, {28'b0, VEC[k][4:1]});
            check($sformatf("R9 irq vec%0d", k), {31'b0, irq_out}, {31'b0, VEC[k][0]});
            rd(OFS_STAT, v);
            check($sformatf("R7 stat vec%0d", k), v, {28'b0, VEC[k][4:1] & ~VEC[k][16:13]});
        end

        // R2: read-back, upper bits and unmapped offset
        do_reset();
        wr(OFS_TYPE, 32'hFFFF_FFFF);
        rd(OFS_TYPE, v);   check("R2 type readback", v, 32'h3FFF_FFFF);
        wr(OFS_DEBLEN, 32'h0000_01A5);
        rd(OFS_DEBLEN, v); check("R2 deblen readback", v, 32'h0000_00A5);
        rd(8'h10, v);      check("R2 unmapped", v, 0);

        // R5 R6: rising edge on line 5 is sticky, acknowledge clears only its bit
        do_reset();
        wr(OFS_TYPE, 32'h20); wr(OFS_POL, 32'h20); wr(OFS_ENABLE, 32'h20);
        line_in[5] = 1'b1; cycles(4);
        rd(OFS_RAW, v); check("R5 edge set", v, 32'h20);
        line_in[5] = 1'b0; cycles(4);
        rd(OFS_RAW, v); check("R5 sticky after release", v, 32'h20);
        check("R5 irq", {31'b0, irq_out}, 1);
        wr(OFS_ACK, 32'h40);
        rd(OFS_RAW, v); check("R6 other bit no effect", v, 32'h20);
        wr(OFS_ACK, 32'h20);
        rd(OFS_RAW, v); check("R6 ack clears", v, 0);
        check("R6 irq low", {31'b0, irq_out}, 0);

        // R4: low polarity in edge mode catches the falling edge only
        do_reset();
        wr(OFS_TYPE, 32'h40); wr(OFS_ENABLE, 32'h40);
        line_in[6] = 1'b1; cycles(5);
        rd(OFS_RAW, v); check("R4 rising ignored", v, 0);
        line_in[6] = 1'b0; cycles(4);
        rd(OFS_RAW, v); check("R4 falling caught", v, 32'h40);

        // R8: disabling discards the sticky bit
        wr(OFS_ENABLE, 32'h0);
        rd(OFS_RAW, v); check("R8 disabled", v, 0);
        wr(OFS_ENABLE, 32'h40);
        rd(OFS_RAW, v); check("R8 not restored", v, 0);

        // R11: exact two-edge latency of a lone active-high line
        do_reset();
        wr(OFS_POL, 32'h1); wr(OFS_ENABLE, 32'h1);
        line_in[0] = 1'b1;
        cycles(1); check("R11 one edge", {31'b0, irq_out}, 0);
        cycles(1); check("R11 two edges", {31'b0, irq_out}, 1);
        line_in[0] = 1'b0;
        cycles(2); check("R11 follows low", {31'b0, irq_out}, 0);

        // R10: debounce on line 7 with L=5, line 8 unfiltered
        do_reset();
        wr(OFS_DEBLEN, 32'd5); wr(OFS_DEBSEL, 32'h80);
        wr(OFS_POL, 32'h180); wr(OFS_ENABLE, 32'h180);
        line_in[8:7] = 2'b11;
        cycles(2);
        rd(OFS_RAW, v); check("R10 unfiltered line passes", v, 32'h100);
        cycles(1);
        line_in[8:7] = 2'b00;
        cycles(10);
        rd(OFS_RAW, v); check("R10 short pulse rejected", v, 0);
        line_in[7] = 1'b1; cycles(20);
        rd(OFS_RAW, v); check("R10 long level accepted", v, 32'h80);
        line_in[7] = 1'b0; cycles(20);
        rd(OFS_RAW, v); check("R10 release accepted", v, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule